// File: doc/BRIEF.md
# Delay Line Unit Calibration Sequencer

This block calibrates an external tapped delay line before phase tuning. It searches for the smallest per-cell delay setting (the "unit" value) at which the whole line covers one period of the input clock. For each candidate it turns on the line and its sampler, then writes a configuration word. The word carries the unit value and a probe tap select one above the last real delay cell. The block then waits for the line to report a measured length with a valid flag.

A candidate qualifies when the measured length is nonzero and fits inside the 11-cell span. The block keeps the first qualifying unit value. It takes the index of the top set bit of that length as the highest usable tap. If a candidate never reports within a timeout, the sequencer gives up on it and tries the next one. If no unit value qualifies, the run ends in error. Software starts a run and collects the results through a two-address register port.

Top module: `dly_unit_cal`

## Requirements
- R1: After reset the block is idle. Status reads zero, both results read zero, and the enable, sampler-enable and configuration-write outputs are low.
- R2: Each trial issues a one-cycle configuration write. The write word holds the probe tap select 12 in bits 3:0 and the trial unit value in bits 14:8. Line enable and sampler enable are both high while a run is active and low when idle.
- R3: A run starts at unit value 0, and each later trial uses the previous unit value plus one. A run issues exactly one write per trial.
- R4: After a write, the block waits for the length-valid input. The run ends at the first unit value whose reported length lies in 1..2047. That unit value is reported as the result.
- R5: On success, the reported maximum tap is the bit index of the most significant set bit of the qualifying length.
- R6: A reported length of 0, or of 2048 or more, does not qualify. The sweep moves on to the next unit value.
- R7: If no valid length arrives within TMO = CLK_MHZ*TMO_US cycles after a write, that unit value is abandoned. The timer restarts for every trial, so consecutive writes of timed-out trials are TMO+2 cycles apart.
- R8: If unit value 127 completes without qualifying, the run ends with error set, done clear and both results zero.
- R9: A start request while a run is active is ignored. The run keeps sweeping without restarting, and its result is unchanged.
- R10: Done and error stay set until the next accepted start, which clears both and also clears the results.
- R11: Register map. Address 0: a write with data 1 requests a start; a read returns busy in bit 0, done in bit 1 and error in bit 2. Address 1: a read returns the unit result in bits 6:0 and the maximum tap in bits 11:8; writes there do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 control/status, 1 results) |
| reg_wdata | input | 1 | Write data; 1 at address 0 requests a start |
| reg_rdata | output | 16 | Read data for reg_addr |
| dl_en | output | 1 | Delay line enable |
| dl_smp_en | output | 1 | Delay line sampler enable |
| dl_cfg_wr | output | 1 | Configuration write strobe |
| dl_cfg_wdata | output | 32 | Configuration word (tap select 3:0, unit 14:8) |
| dl_len | input | 12 | Measured line length |
| dl_len_vld | input | 1 | Measured length is valid |

## Verification
The line is modelled as a lookup of length and silence per unit value, with a chosen response latency. Directed patterns cover several cases. A qualifying length at unit 0 with value 1 separates the first-trial path and a zero tap. Boundary lengths 0, 2048, 4095 and 2047 separate the range test from an off-by-one. Back-to-back silent trials expose the per-trial timer reload through the write spacing. An all-failing sweep and a match only at unit 127 check the end of the sweep. Random tables mix qualifying points, out-of-range lengths, silent trials and latencies, so that the first-match rule and the top-bit search are compared against an independent scan.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;
  // configuration word field positions decoded by the delay line
  localparam int SEL_LSB  = 0;
  localparam int UNIT_LSB = 8;

  // register read layout
  localparam int STS_BUSY     = 0;
  localparam int STS_DONE     = 1;
  localparam int STS_ERR      = 2;
  localparam int RES_UNIT_LSB = 0;
  localparam int RES_TAP_LSB  = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT,
    ST_NEXT
  } cal_state_e;
endpackage

// File: rtl/dlcal_timer.sv
module dlcal_timer #(
  parameter int CNT_MAX = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] RELOAD = CW'(CNT_MAX - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (tick && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dlcal_eval.sv
module dlcal_eval #(
  parameter int LEN_W   = 12,
  parameter int N_CELLS = 11,
  parameter int TAP_W   = 4
) (
  input  logic [LEN_W-1:0] len,
  output logic             qualify,
  output logic [TAP_W-1:0] top_bit
);
  logic [LEN_W-1:0] over;

  // bits at or above the cell count mark a length too long for the line
  always_comb begin
    over = '0;
    for (int i = N_CELLS; i < LEN_W; i++) begin
      over[i] = len[i];
    end
  end

  assign qualify = (len != '0) && (over == '0);

  always_comb begin
    top_bit = '0;
    for (int i = 0; i < LEN_W; i++) begin
      if (len[i]) top_bit = TAP_W'(i);
    end
  end
endmodule

// File: rtl/dlcal_regs.sv
module dlcal_regs
  import dlcal_pkg::*;
#(
  parameter int UNIT_W = 7,
  parameter int TAP_W  = 4,
  parameter int RD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic              reg_wdata,
  output logic [RD_W-1:0]   reg_rdata,
  output logic              start_req,
  input  logic              busy,
  input  logic              launch,
  input  logic              succ,
  input  logic              fail,
  input  logic [UNIT_W-1:0] res_unit,
  input  logic [TAP_W-1:0]  res_tap,
  output logic              done_o,
  output logic              err_o
);
  logic              done_q, done_d, err_q, err_d;
  logic [UNIT_W-1:0] unit_q, unit_d;
  logic [TAP_W-1:0]  tap_q, tap_d;
  logic              upd_en;

  assign start_req = reg_wr && (reg_addr == 1'b0) && reg_wdata;

  always_comb begin
    upd_en = launch || succ || fail;
    done_d = done_q;
    err_d  = err_q;
    unit_d = unit_q;
    tap_d  = tap_q;
    if (launch) begin
      done_d = 1'b0;
      err_d  = 1'b0;
      unit_d = '0;
      tap_d  = '0;
    end else if (succ) begin
      done_d = 1'b1;
      unit_d = res_unit;
      tap_d  = res_tap;
    end else if (fail) begin
      err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unit_q <= '0;
      tap_q  <= '0;
    end else if (upd_en) begin
      done_q <= done_d;
      err_q  <= err_d;
      unit_q <= unit_d;
      tap_q  <= tap_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 1'b0) begin
      reg_rdata[STS_BUSY] = busy;
      reg_rdata[STS_DONE] = done_q;
      reg_rdata[STS_ERR]  = err_q;
    end else begin
      reg_rdata[RES_UNIT_LSB +: UNIT_W] = unit_q;
      reg_rdata[RES_TAP_LSB +: TAP_W]   = tap_q;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dly_unit_cal.sv
module dly_unit_cal
  import dlcal_pkg::*;
#(
  parameter int CLK_MHZ = 125,
  parameter int TMO_US  = 1000,
  parameter int UNIT_W  = 7,
  parameter int SEL_W   = 4,
  parameter int LEN_W   = 12,
  parameter int N_CELLS = 11,
  parameter int CFG_W   = 32,
  parameter int RD_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic             reg_wdata,
  output logic [RD_W-1:0]  reg_rdata,
  output logic             dl_en,
  output logic             dl_smp_en,
  output logic             dl_cfg_wr,
  output logic [CFG_W-1:0] dl_cfg_wdata,
  input  logic [LEN_W-1:0] dl_len,
  input  logic             dl_len_vld
);
  localparam int TMO_CYC = CLK_MHZ * TMO_US;
  localparam int TAP_W   = $clog2(LEN_W);
  localparam logic [SEL_W-1:0]  PROBE_SEL = SEL_W'(N_CELLS + 1);
  localparam logic [UNIT_W-1:0] UNIT_LAST = '1;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  cal_state_e        state_q, state_d;
  logic [UNIT_W-1:0] unit_q, unit_d;
  logic              unit_en;
  logic              launch, succ, fail;
  logic              tmr_load, tmr_tick, tmr_expired;
  logic              start_req;
  logic              len_ok;
  logic [TAP_W-1:0]  len_top;
  logic              sts_busy, sts_done, sts_err;

  assign sts_busy = (state_q != ST_IDLE);

  dlcal_timer #(
    .CNT_MAX (TMO_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (tmr_load),
    .tick    (tmr_tick),
    .expired (tmr_expired)
  );

  dlcal_eval #(
    .LEN_W   (LEN_W),
    .N_CELLS (N_CELLS),
    .TAP_W   (TAP_W)
  ) u_eval (
    .len     (dl_len),
    .qualify (len_ok),
    .top_bit (len_top)
  );

  dlcal_regs #(
    .UNIT_W (UNIT_W),
    .TAP_W  (TAP_W),
    .RD_W   (RD_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .start_req (start_req),
    .busy      (sts_busy),
    .launch    (launch),
    .succ      (succ),
    .fail      (fail),
    .res_unit  (unit_q),
    .res_tap   (len_top),
    .done_o    (sts_done),
    .err_o     (sts_err)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    unit_d   = unit_q;
    unit_en  = 1'b0;
    launch   = 1'b0;
    succ     = 1'b0;
    fail     = 1'b0;
    tmr_load = 1'b0;
    tmr_tick = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          launch  = 1'b1;
          unit_en = 1'b1;
          unit_d  = '0;
          state_d = ST_PROG;
        end
      end
      ST_PROG: begin
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        tmr_tick = 1'b1;
        if (dl_len_vld) begin
          if (len_ok) begin
            succ    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_NEXT;
          end
        end else if (tmr_expired) begin
          state_d = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (unit_q == UNIT_LAST) begin
          fail    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          unit_en = 1'b1;
          unit_d  = unit_q + 1'b1;
          state_d = ST_PROG;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      unit_q <= '0;
    end else if (unit_en) begin
      unit_q <= unit_d;
    end
  end

  // delay line drive
  assign dl_en     = sts_busy;
  assign dl_smp_en = sts_busy;
  assign dl_cfg_wr = (state_q == ST_PROG);

  always_comb begin
    dl_cfg_wdata = '0;
    dl_cfg_wdata[SEL_LSB +: SEL_W]   = PROBE_SEL;
    dl_cfg_wdata[UNIT_LSB +: UNIT_W] = unit_q;
  end
endmodule

// File: rtl/dlcal_checker.sv
module dlcal_checker
  import dlcal_pkg::*;
#(
  parameter int UNIT_W  = 7,
  parameter int SEL_W   = 4,
  parameter int N_CELLS = 11,
  parameter int CFG_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              start_req,
  input logic              wr,
  input logic [CFG_W-1:0]  wdata,
  input logic              en,
  input logic              smp,
  input logic [UNIT_W-1:0] unit
);
  localparam logic [SEL_W-1:0] PROBE = SEL_W'(N_CELLS + 1);

  p_probe_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (wdata[SEL_LSB +: SEL_W] == PROBE));

  p_ctrl_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (en && smp));

  p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !wr);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr && !en && !smp));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (unit >= $past(unit)));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_req) |=> done);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start_req) |=> err);
endmodule

bind dly_unit_cal dlcal_checker #(
  .UNIT_W  (UNIT_W),
  .SEL_W   (SEL_W),
  .N_CELLS (N_CELLS),
  .CFG_W   (CFG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (sts_busy),
  .done      (sts_done),
  .err       (sts_err),
  .start_req (start_req),
  .wr        (dl_cfg_wr),
  .wdata     (dl_cfg_wdata),
  .en        (dl_en),
  .smp       (dl_smp_en),
  .unit      (unit_q)
);

// File: tb/dly_unit_cal_test.sv
module dly_unit_cal_test;
  localparam int TMO = 125;     // CLK_MHZ 125 * TMO_US 1
  localparam int WD_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic        reg_wdata = 1'b0;
  logic [15:0] reg_rdata;
  logic        dl_en, dl_smp_en, dl_cfg_wr;
  logic [31:0] dl_cfg_wdata;
  logic [11:0] m_len = '0;
  logic        m_vld = 1'b0;

  always #4 clk = ~clk;

  dly_unit_cal #(.TMO_US(1)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dl_en(dl_en),
    .dl_smp_en(dl_smp_en), .dl_cfg_wr(dl_cfg_wr), .dl_cfg_wdata(dl_cfg_wdata),
    .dl_len(m_len), .dl_len_vld(m_vld)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural delay line: length and silence per unit value
  logic [11:0] len_tab [128];
  bit          sil_tab [128];
  int          lat = 2;
  int          m_cnt = 0;
  bit          m_act = 1'b0;
  int          m_unit = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dl_cfg_wr) begin
      m_unit <= int'(dl_cfg_wdata[14:8]);
      m_cnt  <= lat;
      m_vld  <= 1'b0;
      m_act  <= 1'b1;
    end else if (m_act) begin
      if (m_cnt == 0) begin
        m_act <= 1'b0;
        if (!sil_tab[m_unit]) begin
          m_vld <= 1'b1;
          m_len <= len_tab[m_unit];
        end
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  // write monitor
  int exp_unit = 0;
  int wr_idx = 0;
  int last_wr = 0;
  int gaps [8];

  always @(negedge clk) begin
    if (dl_cfg_wr) begin
      check(dl_cfg_wdata[3:0] == 4'd12, "R2 probe tap", int'(dl_cfg_wdata[3:0]), 12);
      check(dl_en && dl_smp_en, "R2 enables", int'({dl_en, dl_smp_en}), 3);
      check(int'(dl_cfg_wdata[14:8]) == exp_unit, "R3 unit sequence",
            int'(dl_cfg_wdata[14:8]), exp_unit);
      if (wr_idx < 8) gaps[wr_idx] = cyc - last_wr;
      last_wr = cyc;
      wr_idx++;
      exp_unit++;
    end
  end

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic void exp_find(output bit ok, output int u, output int t);
    ok = 0; u = 0; t = 0;
    for (int i = 0; i < 128; i++) begin
      if (!ok && !sil_tab[i] && len_tab[i] != 0 && len_tab[i] < 12'd2048) begin
        ok = 1;
        u = i;
        for (int b = 0; b < 12; b++) if (len_tab[i][b]) t = b;
      end
    end
  endfunction

  task automatic clear_tabs();
    for (int i = 0; i < 128; i++) begin
      len_tab[i] = '0;
      sil_tab[i] = 1'b0;
    end
  endtask

  task automatic reg_write(input bit a, input bit d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic start_run();
    exp_unit = 0;
    wr_idx = 0;
    last_wr = cyc;
    reg_write(1'b0, 1'b1);
  endtask

  task automatic wait_idle();
    reg_addr = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (!reg_rdata[0]) break;
    end
  endtask

  task automatic check_result(input string nm);
    bit ok; int u; int t;
    exp_find(ok, u, t);
    @(negedge clk);
    reg_addr = 1'b0;
    #1;
    check(reg_rdata[2:0] == (ok ? 3'b010 : 3'b100), {nm, " R11 R8 status"},
          int'(reg_rdata[2:0]), ok ? 2 : 4);
    reg_addr = 1'b1;
    #1;
    check(int'(reg_rdata[6:0]) == (ok ? u : 0), {nm, " R4 unit"}, int'(reg_rdata[6:0]), u);
    check(int'(reg_rdata[11:8]) == (ok ? t : 0), {nm, " R5 max tap"}, int'(reg_rdata[11:8]), t);
    reg_addr = 1'b0;
  endtask

  task automatic run_case(input string nm);
    start_run();
    wait_idle();
    check_result(nm);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_tabs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_addr = 1'b0; #1;
    check(reg_rdata[2:0] == 3'b000, "R1 status", int'(reg_rdata[2:0]), 0);
    reg_addr = 1'b1; #1;
    check(reg_rdata == 16'h0, "R1 results", int'(reg_rdata), 0);
    check(!dl_en && !dl_smp_en && !dl_cfg_wr, "R1 line outputs",
          int'({dl_en, dl_smp_en, dl_cfg_wr}), 0);
    reg_addr = 1'b0;

    // R4 R5 first unit qualifies with length 1
    clear_tabs(); len_tab[0] = 12'd1;
    run_case("first");

    // R6 boundary lengths rejected
    clear_tabs();
    len_tab[0] = 12'd0; len_tab[1] = 12'd2048; len_tab[2] = 12'd4095;
    len_tab[3] = 12'd0; len_tab[4] = 12'd2048; len_tab[5] = 12'd2047;
    run_case("R6 bounds");

    // R7 silent trials and timer reload
    clear_tabs(); sil_tab[0] = 1; sil_tab[1] = 1; len_tab[2] = 12'h040;
    run_case("R7 timeout");
    check(gaps[1] == TMO + 2, "R7 first timeout spacing", gaps[1], TMO + 2);
    check(gaps[2] == TMO + 2, "R7 reload spacing", gaps[2], TMO + 2);

    // R8 exhaustion
    clear_tabs();
    for (int i = 0; i < 128; i += 16) sil_tab[i] = 1;
    for (int i = 1; i < 128; i += 3) len_tab[i] = 12'hA00;
    run_case("R8 exhaust");
    check(exp_unit == 128, "R8 trial count", exp_unit, 128);

    // match only at the last unit value
    clear_tabs(); len_tab[127] = 12'h100;
    run_case("R4 last unit");

    // R9 start while busy is ignored
    clear_tabs();
    for (int i = 0; i < 10; i++) sil_tab[i] = 1;
    len_tab[12] = 12'h3F0;
    start_run();
    repeat (300) @(negedge clk);
    reg_write(1'b0, 1'b1);
    reg_addr = 1'b0; #1;
    check(reg_rdata[0] == 1'b1, "R9 still busy", int'(reg_rdata[0]), 1);
    wait_idle();
    check_result("R9 ignore");

    // R10 sticky flags, writes that are not a start
    repeat (40) @(negedge clk);
    reg_addr = 1'b0; #1;
    check(reg_rdata[1] == 1'b1, "R10 done sticky", int'(reg_rdata[1]), 1);
    reg_write(1'b0, 1'b0);
    reg_write(1'b1, 1'b1);
    reg_addr = 1'b0; #1;
    check(reg_rdata[2:0] == 3'b010, "R11 R10 non-start writes", int'(reg_rdata[2:0]), 2);
    clear_tabs(); len_tab[3] = 12'h007;
    start_run();
    reg_addr = 1'b0; #1;
    check(reg_rdata[2:0] == 3'b001, "R10 start clears", int'(reg_rdata[2:0]), 1);
    reg_addr = 1'b1; #1;
    check(reg_rdata == 16'h0, "R10 results cleared", int'(reg_rdata), 0);
    wait_idle();
    check_result("R10 rerun");

    // random tables
    for (int k = 0; k < 16; k++) begin
      int q;
      clear_tabs();
      q = int'($urandom % 140);
      lat = int'($urandom % 8);
      for (int i = 0; i < 128; i++) begin
        if (i == q) begin
          len_tab[i] = 12'(1 + $urandom % 2047);
        end else if (i > q) begin
          len_tab[i] = 12'($urandom);
          sil_tab[i] = ($urandom % 8) == 0;
        end else begin
          case ($urandom % 8)
            0: sil_tab[i] = 1'b1;
            1, 2, 3: len_tab[i] = 12'd0;
            default: len_tab[i] = 12'(2048 + $urandom % 2048);
          endcase
        end
      end
      run_case("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule